// File: doc/BRIEF.md
# Two-Bank RAM with Per-Bank Access Enable

This block is a small on-chip RAM split into two banks of equal size. An 8-bit control register holds one enable bit per bank. The CPU reaches the RAM through a 32-bit memory port that carries a byte address, a write strobe, a fetch tag and byte enables. The register has its own byte-wide port. While a bank is enabled it behaves as ordinary RAM. While it is disabled, writes to it are dropped and reads or fetches return the fixed pattern 0xDEADBEEF, and each blocked access raises an error pulse.

Each bank is cut into pages. Every page has one posted-write entry, which holds the word index, the data and the byte enables of the latest write to that page. The entry is committed to the array only when a later read or write reaches the same page. Reads of a location whose write is still posted see the posted bytes merged over the array contents. When an enable bit goes from 1 to 0, the posted entries of that bank are discarded, so data that was never committed is lost. Two reset inputs set the reset behaviour. A cold reset restores the register. A warm reset keeps the register and clears only the access state and the posted entries; the array contents are never reset.

Bank size and page size are parameters. The defaults are 2 KB banks with 256-byte pages, and a setting of 14 and 10 gives 16 KB banks with 1 KB pages. Two state machines make up the control. The access guard has the states GRD_OPEN and GRD_SHADOW:
- arm: an accepted register write moves it to GRD_SHADOW.
- settle: a cycle with no register write moves it back to GRD_OPEN.

Each page entry has the states PG_EMPTY and PG_HELD:
- post: a write moves the entry from PG_EMPTY to PG_HELD.
- repost: a write on a held entry commits the old entry and holds the new one.
- drain: a read commits the entry and moves it to PG_EMPTY.
- discard: a cleared enable bit or a reset empties the entry.

Top module: `ramen_banked_ram`

## Requirements
- R1: After a cold reset (cold_rst_n low) the register reads 0xFF, so both banks are enabled.
- R2: A warm reset (warm_rst_n low with cold_rst_n high) leaves the register value unchanged, and register writes made during it are ignored.
- R3: Only register writes with reg_size = 0 (byte) are accepted. Writes with size 1 (16-bit) or 2 (32-bit) leave the register unchanged.
- R4: Register bits 7 to 2 always read as 1, whatever value is written to them.
- R5: Register bit 1 enables the upper bank (mem_addr bit BANK_ADDR_W = 1). Bit 0 enables the lower bank (that address bit = 0). A value of 1 means enabled.
- R6: A write to a disabled bank changes no stored data, and mem_err is 1 in the cycle after the request.
- R7: A read or fetch of a disabled bank returns 0xDEADBEEF with mem_rvalid = 1 and mem_err = 1 in the cycle after the request.
- R8: A read or fetch (mem_fetch = 1 overrides mem_we) of an enabled bank returns the stored word with mem_rvalid = 1 in the cycle after the request. On a write, only the byte lanes whose mem_be bit is 1 (bit n covers data bits 8n+7..8n) are changed.
- R9: A read of a location that has a posted write returns the posted bytes merged over the array contents.
- R10: A posted write is committed only by a later access to the same page. Accesses to other pages do not commit it.
- R11: Clearing a bank's enable bit discards that bank's posted writes that were never committed.
- R12: A memory request made in the cycle right after an accepted register write is serviced normally. mem_hazard is 1 in the cycle after that request and 0 for requests made at other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Active-low reset that also restores the register |
| warm_rst_n | input | 1 | Active-low reset that keeps the register |
| reg_wr | input | 1 | Register write strobe |
| reg_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_fetch | input | 1 | Instruction fetch tag, treated as a read |
| mem_addr | input | BANK_ADDR_W+1 | Byte address; top bit selects the bank |
| mem_be | input | 4 | Byte enables for writes |
| mem_wdata | input | 32 | Write data |
| mem_rdata | output | 32 | Read data, valid with mem_rvalid |
| mem_rvalid | output | 1 | Read response strobe |
| mem_err | output | 1 | Pulses for a blocked access |
| mem_hazard | output | 1 | Pulses for an access made in the cycle after a register write |

## Verification
The bench writes the same location twice so that the second write is still posted when that bank is switched off and on again. A design that commits on any access, or that keeps the posted entry through the disable, would then return the newer word instead of the older one. Other tests set up the reverse case, where an access to the same page commits the write before the disable, and a read that hits a partly posted word, which catches a design that returns the stale array word. Word-sized and longword-sized register writes, writes to the reserved bits and a warm reset all target register corruption. A request made in the cycle right after a register write checks that mem_hazard is set there and nowhere else.

// File: rtl/ramen_pkg.sv
package ramen_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } reg_size_e;

    typedef enum logic {
        GRD_OPEN   = 1'b0,
        GRD_SHADOW = 1'b1
    } guard_state_e;

    typedef enum logic {
        PG_EMPTY = 1'b0,
        PG_HELD  = 1'b1
    } page_state_e;

    localparam logic [31:0] UNDEF_WORD   = 32'hDEADBEEF;
    localparam int          NUM_BANKS    = 2;
    localparam int          LANES        = 4;
    localparam logic [5:0]  RESERVED_ONE = 6'h3F;

endpackage

// File: rtl/ramen_ctrl_reg.sv
module ramen_ctrl_reg
    import ramen_pkg::*;
(
    input  logic                 clk,
    input  logic                 cold_rst_n,
    input  logic                 warm_rst_n,
    input  logic                 wr,
    input  logic [1:0]           size,
    input  logic [7:0]           wdata,
    output logic [NUM_BANKS-1:0] en,
    output logic [NUM_BANKS-1:0] drop,
    output logic                 wr_ok,
    output logic [7:0]           rdata
);

    logic [NUM_BANKS-1:0] en_q;

    always_comb begin
        wr_ok = wr && warm_rst_n && (reg_size_e'(size) == SZ_BYTE);
    end

    // Enable bits live only in the cold reset domain.
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            en_q <= '1;
        end else if (wr_ok) begin
            en_q <= wdata[NUM_BANKS-1:0];
        end
    end

    // A bank loses its posted writes when its enable bit clears.
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_drop
            always_comb begin
                drop[b] = wr_ok && en_q[b] && !wdata[b];
            end
        end
    endgenerate

    always_comb begin
        en    = en_q;
        rdata = {RESERVED_ONE, en_q};
    end

endmodule

// File: rtl/ramen_guard_fsm.sv
module ramen_guard_fsm
    import ramen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reg_wr_ok,
    input  logic mem_req,
    output logic hazard
);

    guard_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GRD_OPEN:   if (reg_wr_ok)  state_d = GRD_SHADOW;
            GRD_SHADOW: if (!reg_wr_ok) state_d = GRD_OPEN;
            default:    state_d = GRD_OPEN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GRD_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hazard <= 1'b0;
        end else begin
            unique case (state_q)
                GRD_OPEN:   hazard <= 1'b0;
                GRD_SHADOW: hazard <= mem_req;
                default:    hazard <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ramen_bank.sv
module ramen_bank
    import ramen_pkg::*;
#(
    parameter int BANK_ADDR_W = 11,
    parameter int PAGE_ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc,
    input  logic                  we,
    input  logic [BANK_ADDR_W-3:0] widx,
    input  logic [LANES-1:0]      be,
    input  logic [31:0]           wdata,
    input  logic                  drop,
    output logic [31:0]           rdata
);

    localparam int WIDX_W    = BANK_ADDR_W - 2;
    localparam int PAGE_W    = BANK_ADDR_W - PAGE_ADDR_W;
    localparam int NUM_PAGES = 1 << PAGE_W;
    localparam int DEPTH     = 1 << WIDX_W;

    logic [31:0]       mem_q [DEPTH];
    page_state_e       pst_q   [NUM_PAGES];
    logic [WIDX_W-1:0] paddr_q [NUM_PAGES];
    logic [31:0]       pdata_q [NUM_PAGES];
    logic [LANES-1:0]  pbe_q   [NUM_PAGES];

    logic [PAGE_W-1:0] pg;
    logic              hit;
    logic              commit;
    logic              fwd;
    logic [31:0]       base;

    always_comb begin
        pg     = widx[WIDX_W-1 -: PAGE_W];
        hit    = (pst_q[pg] == PG_HELD);
        commit = acc && hit;
        fwd    = hit && (paddr_q[pg] == widx);
        base   = mem_q[widx];
    end

    // Page entries: post, repost, drain, discard.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PAGES; p++) begin
                pst_q[p]   <= PG_EMPTY;
                paddr_q[p] <= '0;
                pdata_q[p] <= '0;
                pbe_q[p]   <= '0;
            end
        end else if (drop) begin
            for (int p = 0; p < NUM_PAGES; p++) begin
                pst_q[p] <= PG_EMPTY;
            end
        end else if (acc) begin
            unique case (pst_q[pg])
                PG_EMPTY: begin
                    if (we) begin
                        pst_q[pg]   <= PG_HELD;
                        paddr_q[pg] <= widx;
                        pdata_q[pg] <= wdata;
                        pbe_q[pg]   <= be;
                    end
                end
                PG_HELD: begin
                    if (we) begin
                        paddr_q[pg] <= widx;
                        pdata_q[pg] <= wdata;
                        pbe_q[pg]   <= be;
                    end else begin
                        pst_q[pg] <= PG_EMPTY;
                    end
                end
                default: pst_q[pg] <= PG_EMPTY;
            endcase
        end
    end

    // Array write port: only commits of a held entry reach it.
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (commit && pbe_q[pg][l]) begin
                    mem_q[paddr_q[pg]][8*l +: 8] <= pdata_q[pg][8*l +: 8];
                end
            end

            always_comb begin
                rdata[8*l +: 8] = (fwd && pbe_q[pg][l]) ? pdata_q[pg][8*l +: 8]
                                                        : base[8*l +: 8];
            end
        end
    endgenerate

endmodule

// File: rtl/ramen_banked_ram.sv
module ramen_banked_ram
    import ramen_pkg::*;
#(
    parameter int BANK_ADDR_W = 11,
    parameter int PAGE_ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 cold_rst_n,
    input  logic                 warm_rst_n,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_size,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 mem_req,
    input  logic                 mem_we,
    input  logic                 mem_fetch,
    input  logic [BANK_ADDR_W:0] mem_addr,
    input  logic [3:0]           mem_be,
    input  logic [31:0]          mem_wdata,
    output logic [31:0]          mem_rdata,
    output logic                 mem_rvalid,
    output logic                 mem_err,
    output logic                 mem_hazard
);

    localparam int WIDX_W = BANK_ADDR_W - 2;

    logic                 sys_rst_n;
    logic [NUM_BANKS-1:0] en;
    logic [NUM_BANKS-1:0] drop;
    logic                 wr_ok;
    logic                 bank_sel;
    logic                 allowed;
    logic                 is_write;
    logic [WIDX_W-1:0]    widx;
    logic [31:0]          bank_rd [NUM_BANKS];

    always_comb begin
        sys_rst_n = cold_rst_n && warm_rst_n;
        bank_sel  = mem_addr[BANK_ADDR_W];
        allowed   = en[bank_sel];
        is_write  = mem_we && !mem_fetch;
        widx      = mem_addr[BANK_ADDR_W-1:2];
    end

    ramen_ctrl_reg u_reg (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .warm_rst_n (warm_rst_n),
        .wr         (reg_wr),
        .size       (reg_size),
        .wdata      (reg_wdata),
        .en         (en),
        .drop       (drop),
        .wr_ok      (wr_ok),
        .rdata      (reg_rdata)
    );

    ramen_guard_fsm u_guard (
        .clk       (clk),
        .rst_n     (sys_rst_n),
        .reg_wr_ok (wr_ok),
        .mem_req   (mem_req),
        .hazard    (mem_hazard)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic acc_b;
            always_comb begin
                acc_b = mem_req && allowed && (bank_sel == b[0]);
            end
            ramen_bank #(
                .BANK_ADDR_W (BANK_ADDR_W),
                .PAGE_ADDR_W (PAGE_ADDR_W)
            ) u_bank (
                .clk   (clk),
                .rst_n (sys_rst_n),
                .acc   (acc_b),
                .we    (is_write),
                .widx  (widx),
                .be    (mem_be),
                .wdata (mem_wdata),
                .drop  (drop[b]),
                .rdata (bank_rd[b])
            );
        end
    endgenerate

    // Response register.
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            mem_rvalid <= 1'b0;
            mem_err    <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= mem_req && !is_write;
            mem_err    <= mem_req && !allowed;
            if (mem_req && !is_write) begin
                mem_rdata <= allowed ? bank_rd[bank_sel] : UNDEF_WORD;
            end
        end
    end

endmodule

// File: rtl/ramen_banked_ram_chk.sv
module ramen_banked_ram_chk #(
    parameter int BANK_ADDR_W = 11
) (
    input logic                 clk,
    input logic                 cold_rst_n,
    input logic                 warm_rst_n,
    input logic                 reg_wr,
    input logic [1:0]           reg_size,
    input logic [7:0]           reg_rdata,
    input logic                 mem_req,
    input logic                 mem_we,
    input logic                 mem_fetch,
    input logic [BANK_ADDR_W:0] mem_addr,
    input logic [31:0]          mem_rdata,
    input logic                 mem_rvalid,
    input logic                 mem_err,
    input logic                 mem_hazard
);

    // R2
    warm_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !warm_rst_n |=> $stable(reg_rdata));

    // R3
    size_ignore_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (reg_wr && reg_size != 2'd0) |=> $stable(reg_rdata));

    // R6
    blocked_err_chk: assert property (@(posedge clk) disable iff (!(cold_rst_n && warm_rst_n))
        mem_err |-> $past(mem_req && !reg_rdata[mem_addr[BANK_ADDR_W]]));

    // R7
    undef_word_chk: assert property (@(posedge clk) disable iff (!(cold_rst_n && warm_rst_n))
        (mem_err && mem_rvalid) |-> (mem_rdata == 32'hDEADBEEF));

    // R8
    rvalid_src_chk: assert property (@(posedge clk) disable iff (!(cold_rst_n && warm_rst_n))
        mem_rvalid |-> $past(mem_req && (!mem_we || mem_fetch)));

    // R12
    hazard_src_chk: assert property (@(posedge clk) disable iff (!(cold_rst_n && warm_rst_n))
        mem_hazard |-> ($past(mem_req) && $past(reg_wr && reg_size == 2'd0 && warm_rst_n, 2)));

endmodule

bind ramen_banked_ram ramen_banked_ram_chk #(.BANK_ADDR_W(BANK_ADDR_W)) u_chk (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .warm_rst_n (warm_rst_n),
    .reg_wr     (reg_wr),
    .reg_size   (reg_size),
    .reg_rdata  (reg_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_fetch  (mem_fetch),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .mem_rvalid (mem_rvalid),
    .mem_err    (mem_err),
    .mem_hazard (mem_hazard)
);

// File: tb/ramen_banked_ram_tb.sv
module ramen_banked_ram_tb;

    localparam int BAW = 11;

    logic         clk = 1'b0;
    logic         cold_rst_n, warm_rst_n;
    logic         reg_wr;
    logic [1:0]   reg_size;
    logic [7:0]   reg_wdata, reg_rdata;
    logic         mem_req, mem_we, mem_fetch;
    logic [BAW:0] mem_addr;
    logic [3:0]   mem_be;
    logic [31:0]  mem_wdata, mem_rdata;
    logic         mem_rvalid, mem_err, mem_hazard;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #4 clk = ~clk;

    ramen_banked_ram #(.BANK_ADDR_W(BAW), .PAGE_ADDR_W(8)) u_dut (
        .clk (clk), .cold_rst_n (cold_rst_n), .warm_rst_n (warm_rst_n),
        .reg_wr (reg_wr), .reg_size (reg_size), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .mem_req (mem_req), .mem_we (mem_we),
        .mem_fetch (mem_fetch), .mem_addr (mem_addr), .mem_be (mem_be),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .mem_rvalid (mem_rvalid),
        .mem_err (mem_err), .mem_hazard (mem_hazard)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sz, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_size = sz; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic mem_wr(input logic [BAW:0] a, input logic [3:0] be,
                          input logic [31:0] d, input logic exp_err, input string req);
        @(negedge clk);
        mem_req = 1'b1; mem_we = 1'b1; mem_fetch = 1'b0;
        mem_addr = a; mem_be = be; mem_wdata = d;
        @(negedge clk);
        mem_req = 1'b0; mem_we = 1'b0;
        chk(req, {31'd0, mem_err}, {31'd0, exp_err});
    endtask

    task automatic mem_rd(input logic [BAW:0] a, input logic fetch,
                          input logic [31:0] exp_d, input logic exp_err, input string req);
        @(negedge clk);
        mem_req = 1'b1; mem_we = fetch; mem_fetch = fetch; mem_addr = a;
        @(negedge clk);
        mem_req = 1'b0; mem_we = 1'b0; mem_fetch = 1'b0;
        chk(req, {30'd0, mem_rvalid, mem_err}, {30'd0, 1'b1, exp_err});
        chk(req, mem_rdata, exp_d);
    endtask

    task automatic t_reset;
        chk("R1 reset value", {24'd0, reg_rdata}, 32'h0000_00FF);
        chk("R1 idle outputs", {29'd0, mem_rvalid, mem_err, mem_hazard}, 32'd0);
    endtask

    task automatic t_basic;
        mem_wr(12'h010, 4'hF, 32'h1234_5678, 1'b0, "R8 write lower");
        mem_rd(12'h010, 1'b0, 32'h1234_5678, 1'b0, "R9 read posted");
        mem_wr(12'h810, 4'hF, 32'hCAFE_0001, 1'b0, "R5 write upper");
        mem_rd(12'h810, 1'b1, 32'hCAFE_0001, 1'b0, "R8 fetch upper");
        mem_rd(12'h010, 1'b0, 32'h1234_5678, 1'b0, "R8 read committed");
    endtask

    task automatic t_bytes;
        mem_wr(12'h020, 4'hF, 32'h1122_3344, 1'b0, "R8 full write");
        mem_rd(12'h020, 1'b0, 32'h1122_3344, 1'b0, "R8 full read");
        mem_wr(12'h020, 4'b0010, 32'hAABB_CCDD, 1'b0, "R8 lane write");
        mem_rd(12'h020, 1'b0, 32'h1122_CC44, 1'b0, "R9 merged lane read");
    endtask

    task automatic t_reg_access;
        reg_write(2'd1, 8'h00);
        chk("R3 16-bit write ignored", {24'd0, reg_rdata}, 32'hFF);
        reg_write(2'd2, 8'h00);
        chk("R3 32-bit write ignored", {24'd0, reg_rdata}, 32'hFF);
        reg_write(2'd0, 8'h00);
        chk("R4 reserved read as one", {24'd0, reg_rdata}, 32'hFC);
        reg_write(2'd0, 8'hFF);
        chk("R4 restore", {24'd0, reg_rdata}, 32'hFF);
    endtask

    task automatic t_block;
        mem_wr(12'h040, 4'hF, 32'h0BAD_F00D, 1'b0, "R6 setup");
        mem_rd(12'h040, 1'b0, 32'h0BAD_F00D, 1'b0, "R6 setup commit");
        reg_write(2'd0, 8'hFE);
        mem_wr(12'h040, 4'hF, 32'h5555_5555, 1'b1, "R6 blocked write err");
        mem_rd(12'h040, 1'b0, 32'hDEAD_BEEF, 1'b1, "R7 blocked read");
        mem_rd(12'h040, 1'b1, 32'hDEAD_BEEF, 1'b1, "R7 blocked fetch");
        mem_rd(12'h810, 1'b0, 32'hCAFE_0001, 1'b0, "R5 upper still open");
        reg_write(2'd0, 8'hFF);
        mem_rd(12'h040, 1'b0, 32'h0BAD_F00D, 1'b0, "R6 data untouched");
        reg_write(2'd0, 8'hFD);
        mem_rd(12'h810, 1'b0, 32'hDEAD_BEEF, 1'b1, "R5 upper blocked");
        mem_rd(12'h040, 1'b0, 32'h0BAD_F00D, 1'b0, "R5 lower open");
        reg_write(2'd0, 8'hFF);
    endtask

    task automatic t_posted;
        mem_wr(12'h000, 4'hF, 32'hAAAA_0000, 1'b0, "R10 setup a");
        mem_wr(12'h004, 4'hF, 32'hCCCC_0004, 1'b0, "R10 setup c");
        mem_rd(12'h004, 1'b0, 32'hCCCC_0004, 1'b0, "R10 setup commit");
        mem_wr(12'h000, 4'hF, 32'hBBBB_0000, 1'b0, "R11 post b");
        mem_wr(12'h100, 4'hF, 32'h7777_0100, 1'b0, "R10 other page");
        reg_write(2'd0, 8'hFE);
        reg_write(2'd0, 8'hFF);
        mem_rd(12'h000, 1'b0, 32'hAAAA_0000, 1'b0, "R11 posted data lost");
        mem_wr(12'h000, 4'hF, 32'hBBBB_0000, 1'b0, "R10 post b again");
        mem_rd(12'h004, 1'b0, 32'hCCCC_0004, 1'b0, "R10 same page drain");
        reg_write(2'd0, 8'hFE);
        reg_write(2'd0, 8'hFF);
        mem_rd(12'h000, 1'b0, 32'hBBBB_0000, 1'b0, "R10 committed survives");
    endtask

    task automatic t_hazard;
        @(negedge clk);
        reg_wr = 1'b1; reg_size = 2'd0; reg_wdata = 8'hFF;
        @(negedge clk);
        reg_wr = 1'b0;
        mem_req = 1'b1; mem_we = 1'b0; mem_fetch = 1'b0; mem_addr = 12'h040;
        @(negedge clk);
        mem_req = 1'b0;
        chk("R12 hazard flagged", {31'd0, mem_hazard}, 32'd1);
        chk("R12 access serviced", mem_rdata, 32'h0BAD_F00D);
        mem_rd(12'h040, 1'b0, 32'h0BAD_F00D, 1'b0, "R12 later read");
        chk("R12 no hazard later", {31'd0, mem_hazard}, 32'd0);
    endtask

    task automatic t_resets;
        reg_write(2'd0, 8'hFD);
        @(negedge clk); warm_rst_n = 1'b0;
        reg_wr = 1'b1; reg_size = 2'd0; reg_wdata = 8'hFC;
        @(negedge clk); reg_wr = 1'b0;
        @(negedge clk); warm_rst_n = 1'b1;
        @(negedge clk);
        chk("R2 warm reset keeps reg", {24'd0, reg_rdata}, 32'hFD);
        @(negedge clk); cold_rst_n = 1'b0;
        @(negedge clk); cold_rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cold reset restores reg", {24'd0, reg_rdata}, 32'hFF);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cold_rst_n = 1'b0; warm_rst_n = 1'b0;
        reg_wr = 1'b0; reg_size = 2'd0; reg_wdata = 8'h00;
        mem_req = 1'b0; mem_we = 1'b0; mem_fetch = 1'b0;
        mem_addr = '0; mem_be = 4'h0; mem_wdata = '0;
        repeat (3) @(negedge clk);
        cold_rst_n = 1'b1; warm_rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_bytes();
        t_reg_access();
        t_block();
        t_posted();
        t_hazard();
        t_resets();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule